// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is the serial target through which a host reads and writes a small bank of 8-bit configuration registers. The host lowers chip select, sends a 16-bit instruction and then clocks data bytes. The instruction holds a read flag, a two-bit length code and a 13-bit register address. The register address advances by one after every data byte. The block also presents the current contents of the bank as a flat vector to the logic it configures.

Register 0 configures the serial port itself. Through it the host can move read data to a dedicated output pin, reverse the bit order of the whole link, or put every register back to its default value. Its low nibble is always a bit-reversed copy of its high nibble, so the register decodes the same whichever bit order the host assumes. The serial clock, chip select and data input are brought into the system clock domain through two-stage synchronizers. The serial clock must therefore be slower than the system clock; the bench uses a serial half period of 8 system clocks.

Top module: `spi_cfg_target`

## Requirements
- R1: While reset is low, both output enables are low. Register 0 then reads 0x18, and register i (1 to 7) reads 0x5A XOR i.
- R2: An instruction is 16 bits: bit 15 is the direction (1 = read), bits 14:13 are the length code, and bits 12:0 are the address. In MSB-first order it is sent bit 15 first, and data bytes are sent bit 7 first. Input is sampled on the serial clock rising edge, and read data changes after the falling edge.
- R3: Length code 01 carries one data byte, 10 carries two and 11 carries three. Bytes clocked after that are ignored: nothing is written and no output enable is asserted.
- R4: Length code 00 keeps transferring bytes for as long as the host clocks, until chip select rises.
- R5: The register address increments by one after each data byte, for reads and writes alike.
- R6: A write takes effect when its eighth bit is received. Writes to addresses 8 and above change nothing, and reads from them return 0x00.
- R7: Register 0 reads back as {sdoEn, lsbFirst, 0, 1, 1, 0, lsbFirst, sdoEn}, MSB to LSB. Bit 4 reads 1 whatever was written, and bit 5 always reads 0.
- R8: Register 0 bit 6 set selects LSB-first order for the instruction (bit 0 first) and for the data bytes (bit 0 first), starting with the next transaction. The transaction that writes the bit keeps its old order.
- R9: With register 0 bit 7 clear, read data leaves on sdioOut and sdioOe is high only during the read data bytes. With the bit set, read data leaves on sdoOut under sdoOe, and sdioOe stays low.
- R10: Writing register 0 with bit 5 set returns every register, including register 0, to its R1 value.
- R11: Raising chip select at any point ends the transaction. A partial byte is not written, both output enables drop, and the next transaction starts with a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdioIn | input | 1 | Serial data from the host |
| sdioOut | output | 1 | Read data for the bidirectional data pin |
| sdioOe | output | 1 | Output enable for the bidirectional data pin |
| sdoOut | output | 1 | Read data for the dedicated output pin |
| sdoOe | output | 1 | Output enable for the dedicated output pin |
| ctrlRegs | output | NUM_REGS*8 | Register bank, register i in bits 8i+7:8i |

## Verification
The hardest case to reach is a transaction that changes the port's own behaviour partway through. A streaming write can start at register 0, switch the port to LSB-first order, and then keep clocking data into register 1 in the old MSB-first order. The bench drives exactly that transaction. It then reads the whole bank back in the new order, which shows both that the switch was deferred and that it took effect on the next transaction. Aborts are reached by cutting chip select after a chosen number of serial bits, inside the instruction, inside a write byte and inside a read. A near-exhaustive sweep writes five bytes under every fixed length code from several start addresses, to exercise the point where the transfer count runs out.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [1:0] {
    PH_INSTR,
    PH_DATA,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic lsbFirst;   // bit order latched for the current transaction
    logic sampleBit;  // shift the synchronized input bit in
    logic instrDone;  // last instruction bit arrives this cycle
    logic byteDone;   // last bit of a data byte arrives this cycle
    logic doWrite;    // commit the received byte
    logic loadRead;   // prefetch the next read byte
    logic shiftOut;   // present the next read bit
  } strobe_t;

  function automatic logic [7:0] regDefault(input int idx);
    return (idx == 0) ? 8'h18 : (8'h5A ^ 8'(idx));
  endfunction

endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdioIn,
  input  logic [2:0] instrHead,
  input  logic       cfgLsb,
  input  logic       cfgSdoEn,
  output strobe_t    st,
  output logic       sdiBit,
  output logic       sdioOe,
  output logic       sdoOe
);

  localparam int CNT_W = $clog2(INSTR_W);

  logic [2:0] csPipe;
  logic [2:0] sckPipe;
  logic [1:0] dPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      dPipe   <= '0;
    end else begin
      csPipe  <= {csPipe[1:0], csN};
      sckPipe <= {sckPipe[1:0], sclk};
      dPipe   <= {dPipe[0], sdioIn};
    end
  end

  logic active, start, rise, fall;
  assign active = !csPipe[1];
  assign start  = !csPipe[1] && csPipe[2];
  assign rise   = sckPipe[1] && !sckPipe[2];
  assign fall   = !sckPipe[1] && sckPipe[2];
  assign sdiBit = dPipe[1];

  phase_e     phase;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] bytesLeft;
  logic       stream, rwReg, readActive, tLsb, tSdo;

  logic instrDone, byteDone, lastByte;
  assign instrDone = active && rise && (phase == PH_INSTR) && (bitCnt == CNT_W'(INSTR_W - 1));
  assign byteDone  = active && rise && (phase == PH_DATA) && (bitCnt[2:0] == 3'd7);
  assign lastByte  = !stream && (bytesLeft == 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_INSTR;
      bitCnt     <= '0;
      bytesLeft  <= '0;
      stream     <= 1'b0;
      rwReg      <= 1'b0;
      readActive <= 1'b0;
      tLsb       <= 1'b0;
      tSdo       <= 1'b0;
    end else begin
      if (start) begin
        tLsb <= cfgLsb;
        tSdo <= cfgSdoEn;
      end
      if (!active) begin
        phase      <= PH_INSTR;
        bitCnt     <= '0;
        readActive <= 1'b0;
      end else if (rise) begin
        unique case (phase)
          PH_INSTR: begin
            if (instrDone) begin
              phase      <= PH_DATA;
              bitCnt     <= '0;
              rwReg      <= instrHead[2];
              stream     <= (instrHead[1:0] == 2'b00);
              bytesLeft  <= instrHead[1:0];
              readActive <= instrHead[2];
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (byteDone) begin
              bitCnt <= '0;
              if (lastByte) begin
                phase      <= PH_DONE;
                readActive <= 1'b0;
              end else if (!stream) begin
                bytesLeft <= bytesLeft - 1'b1;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    st.lsbFirst  = tLsb;
    st.sampleBit = active && rise && (phase != PH_DONE);
    st.instrDone = instrDone;
    st.byteDone  = byteDone;
    st.doWrite   = byteDone && !rwReg;
    st.loadRead  = (instrDone && instrHead[2]) || (byteDone && rwReg && !lastByte);
    st.shiftOut  = active && fall && readActive;
  end

  assign sdioOe = readActive && !tSdo;
  assign sdoOe  = readActive && tSdo;

endmodule

// File: rtl/spi_cfg_data.sv
module spi_cfg_data
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic                  sdiBit,
  output logic [2:0]            instrHead,
  output logic                  txBit,
  output logic                  cfgLsb,
  output logic                  cfgSdoEn,
  output logic [NUM_REGS*8-1:0] ctrlRegs
);

  localparam int INSTR_W = ADDR_W + 3;
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam logic [7:0] CFG_DEF = regDefault(0);

  logic [INSTR_W-1:0] shiftWord, nextWord;
  logic [7:0]         rxByte;

  // one shift register serves instruction and data; byte position depends on order
  assign nextWord  = st.lsbFirst ? {sdiBit, shiftWord[INSTR_W-1:1]}
                                 : {shiftWord[INSTR_W-2:0], sdiBit};
  assign rxByte    = st.lsbFirst ? nextWord[INSTR_W-1 -: 8] : nextWord[7:0];
  assign instrHead = nextWord[INSTR_W-1 -: 3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (st.sampleBit) shiftWord <= nextWord;
  end

  logic [ADDR_W-1:0] addr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (st.instrDone) addr <= nextWord[ADDR_W-1:0];
    else if (st.byteDone) addr <= addr + 1'b1;
  end

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             softRst;
  assign hit     = (addr < ADDR_W'(NUM_REGS));
  assign idx     = addr[IDX_W-1:0];
  assign softRst = st.doWrite && hit && (idx == '0) && rxByte[5];

  logic       sdoEnR, lsbR;
  logic [7:0] stored [1:NUM_REGS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoEnR <= CFG_DEF[7];
      lsbR   <= CFG_DEF[6];
      for (int i = 1; i < NUM_REGS; i++) stored[i] <= regDefault(i);
    end else if (softRst) begin
      sdoEnR <= CFG_DEF[7];
      lsbR   <= CFG_DEF[6];
      for (int i = 1; i < NUM_REGS; i++) stored[i] <= regDefault(i);
    end else if (st.doWrite && hit) begin
      if (idx == '0) begin
        sdoEnR <= rxByte[7];
        lsbR   <= rxByte[6];
      end
      for (int i = 1; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) stored[i] <= rxByte;
    end
  end

  logic [7:0] bank [NUM_REGS];
  always_comb begin
    bank[0] = {sdoEnR, lsbR, 1'b0, 1'b1, 1'b1, 1'b0, lsbR, sdoEnR};
    for (int i = 1; i < NUM_REGS; i++) bank[i] = stored[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign ctrlRegs[g*8 +: 8] = bank[g];
  end

  assign cfgLsb   = lsbR;
  assign cfgSdoEn = sdoEnR;

  // readback: first byte from the decoded address, later bytes from address+1
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData;
  always_comb begin
    rdAddr = st.instrDone ? nextWord[ADDR_W-1:0] : addr + 1'b1;
    rdData = (rdAddr < ADDR_W'(NUM_REGS)) ? bank[rdAddr[IDX_W-1:0]] : 8'h00;
  end

  logic [7:0] txShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txBit   <= 1'b0;
    end else if (st.loadRead) begin
      txShift <= rdData;
    end else if (st.shiftOut) begin
      txBit   <= st.lsbFirst ? txShift[0] : txShift[7];
      txShift <= st.lsbFirst ? {1'b0, txShift[7:1]} : {txShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_cfg_target.sv
module spi_cfg_target
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdioIn,
  output logic                  sdioOut,
  output logic                  sdioOe,
  output logic                  sdoOut,
  output logic                  sdoOe,
  output logic [NUM_REGS*8-1:0] ctrlRegs
);

  localparam int INSTR_W = ADDR_W + 3;

  strobe_t    st;
  logic       sdiBit, txBit, cfgLsb, cfgSdoEn;
  logic [2:0] instrHead;

  spi_cfg_ctrl #(.INSTR_W(INSTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .instrHead(instrHead), .cfgLsb(cfgLsb), .cfgSdoEn(cfgSdoEn),
    .st(st), .sdiBit(sdiBit), .sdioOe(sdioOe), .sdoOe(sdoOe)
  );

  spi_cfg_data #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .sdiBit(sdiBit),
    .instrHead(instrHead), .txBit(txBit), .cfgLsb(cfgLsb),
    .cfgSdoEn(cfgSdoEn), .ctrlRegs(ctrlRegs)
  );

  assign sdioOut = txBit;
  assign sdoOut  = txBit;

endmodule

// File: rtl/spi_cfg_target_chk.sv
module spi_cfg_target_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  csN,
  input logic                  sdioOe,
  input logic                  sdoOe,
  input logic [NUM_REGS*8-1:0] ctrlRegs
);

  // R1: no pin driven while held in reset
  always @(posedge clk)
    if (!rstN) a_r1_quiet_in_reset: assert (!sdioOe && !sdoOe);

  // R9: never both pins at once
  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    !(sdioOe && sdoOe));

  // R9: pin choice agrees with register 0 bit 7
  a_r9_sdo_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> ctrlRegs[7]);
  a_r9_sdio_needs_disable: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> !ctrlRegs[7]);

  // R11: enables released once chip select has been high long enough to pass the synchronizer
  a_r11_released_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !(sdioOe || sdoOe));

  // R6: no register changes while the port is deselected
  a_r6_regs_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> $stable(ctrlRegs));

endmodule

bind spi_cfg_target spi_cfg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdioOe(sdioOe), .sdoOe(sdoOe),
  .ctrlRegs(ctrlRegs)
);

// File: tb/spi_cfg_target_tb.sv
module spi_cfg_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;   // serial half period in system clocks
  localparam int NR         = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [NR*8-1:0] ctrlRegs;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_target #(.NUM_REGS(NR), .ADDR_W(13)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .ctrlRegs(ctrlRegs)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] mdl [NR];
  logic mSdo, mLsb;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic oeA [16];
  logic oeB [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void mReset();
    for (int i = 1; i < NR; i++) mdl[i] = 8'h5A ^ 8'(i);
    mSdo = 1'b0;
    mLsb = 1'b0;
  endfunction

  function automatic logic [7:0] mRead(input int a);
    if (a >= NR) return 8'h00;
    if (a == 0) return {mSdo, mLsb, 1'b0, 1'b1, 1'b1, 1'b0, mLsb, mSdo};
    return mdl[a];
  endfunction

  function automatic void mWrite(input int a, input logic [7:0] d);
    if (a < NR) begin
      if (a == 0) begin
        if (d[5]) mReset();
        else begin mSdo = d[7]; mLsb = d[6]; end
      end else mdl[a] = d;
    end
  endfunction

  task automatic xfer(input logic rw, input logic [1:0] code, input logic [12:0] addr,
                      input int nbytes, input int stopAt);
    logic [15:0] iw;
    logic lsb, useSdo, aborted, pin;
    logic [7:0] r;
    int bits, done, cnt;
    iw = {rw, code, addr};
    lsb = mLsb; useSdo = mSdo; aborted = 1'b0; bits = 0; done = 0;
    csN = 1'b0;
    #(H*CLK_PERIOD);
    for (int i = 0; i < 16; i++) begin
      if (bits == stopAt) begin aborted = 1'b1; break; end
      sdioIn = lsb ? iw[i] : iw[15-i];
      #(H*CLK_PERIOD); sclk = 1'b1;
      #(H*CLK_PERIOD); sclk = 1'b0;
      bits++;
    end
    for (int b = 0; b < nbytes && !aborted; b++) begin
      r = '0;
      for (int i = 0; i < 8; i++) begin
        if (bits == stopAt) begin aborted = 1'b1; break; end
        sdioIn = rw ? 1'b0 : (lsb ? wbuf[b][i] : wbuf[b][7-i]);
        #(H*CLK_PERIOD);
        pin = useSdo ? sdoOut : sdioOut;
        if (lsb) r[i] = pin; else r[7-i] = pin;
        if (i == 7) begin oeA[b] = sdioOe; oeB[b] = sdoOe; end
        sclk = 1'b1;
        #(H*CLK_PERIOD); sclk = 1'b0;
        bits++;
      end
      if (!aborted) begin rbuf[b] = r; done++; end
    end
    #(H*CLK_PERIOD);
    csN = 1'b1; sdioIn = 1'b0;
    #(4*H*CLK_PERIOD);
    if (!rw) begin
      cnt = (code == 2'b00) ? done : ((int'(code) < done) ? int'(code) : done);
      for (int k = 0; k < cnt; k++) mWrite(int'(addr) + k, wbuf[k]);
    end
  endtask

  task automatic readAll(input string tag);
    xfer(1'b1, 2'b00, 13'd0, NR, -1);
    for (int k = 0; k < NR; k++) chk(tag, rbuf[k], mRead(k));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(150000*CLK_PERIOD);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    mReset();
    #3;
    #(5*CLK_PERIOD);
    chk("R1 sdioOe in reset", sdioOe, 0);
    chk("R1 sdoOe in reset", sdoOe, 0);
    rstN = 1'b1;
    #(5*CLK_PERIOD);

    // R1, R2, R3: single-byte reads of every register after reset
    for (int a = 0; a < NR; a++) begin
      xfer(1'b1, 2'b01, 13'(a), 1, -1);
      chk("R1 R2 default readback", rbuf[0], mRead(a));
    end

    // R4, R5: streaming write of registers 1..7, streaming read back
    for (int k = 0; k < 7; k++) wbuf[k] = 8'(k*37 + 11);
    xfer(1'b0, 2'b00, 13'd1, 7, -1);
    readAll("R4 R5 stream write/read");
    // R6: stream across the end of the bank
    xfer(1'b1, 2'b00, 13'd6, 4, -1);
    for (int k = 0; k < 4; k++) chk("R6 R5 read past bank", rbuf[k], mRead(6 + k));

    // R3: every fixed length code from several start addresses, extra bytes clocked
    for (int code = 1; code < 4; code++) begin
      for (int s = 1; s < 5; s++) begin
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(code*50 + s*7 + k*3 + 1);
        xfer(1'b0, 2'(code), 13'(s), 5, -1);
        readAll("R3 length-limited write");
      end
      xfer(1'b1, 2'(code), 13'd1, 5, -1);
      for (int k = 0; k < 5; k++) begin
        if (k < code) begin
          chk("R3 R5 counted read byte", rbuf[k], mRead(1 + k));
          chk("R9 sdioOe during read byte", oeA[k], 1);
        end else begin
          chk("R3 no drive after count", oeA[k], 0);
        end
      end
    end

    // R6: unmapped writes change nothing
    wbuf[0] = 8'hC3;
    xfer(1'b0, 2'b01, 13'h1F00, 1, -1);
    xfer(1'b0, 2'b01, 13'd8, 1, -1);
    readAll("R6 unmapped write ignored");

    // R7, R9: dedicated output enable
    wbuf[0] = 8'h99;
    xfer(1'b0, 2'b01, 13'd0, 1, -1);
    xfer(1'b1, 2'b01, 13'd0, 1, -1);
    chk("R7 reg0 readback on sdo", rbuf[0], 8'h99);
    chk("R9 sdoOe with dedicated pin", oeB[0], 1);
    chk("R9 sdioOe quiet with dedicated pin", oeA[0], 0);
    xfer(1'b1, 2'b01, 13'd3, 1, -1);
    chk("R9 data on sdo", rbuf[0], mRead(3));
    wbuf[0] = 8'h00;
    xfer(1'b0, 2'b01, 13'd0, 1, -1);
    xfer(1'b1, 2'b01, 13'd0, 1, -1);
    chk("R7 reserved bit reads one", rbuf[0], 8'h18);
    chk("R9 back on sdio", oeA[0], 1);

    // R8: switch to LSB first mid-stream; the rest of the stream stays MSB first
    wbuf[0] = 8'h5A; wbuf[1] = 8'h35;
    xfer(1'b0, 2'b00, 13'd0, 2, -1);
    readAll("R8 LSB-first readback");
    wbuf[0] = 8'h81; wbuf[1] = 8'h0E;
    xfer(1'b0, 2'b10, 13'd4, 2, -1);
    readAll("R8 LSB-first write");

    // R10: soft reset written in LSB order
    wbuf[0] = 8'h3C;
    xfer(1'b0, 2'b01, 13'd0, 1, -1);
    readAll("R10 soft reset defaults");
    chk("R10 soft reset self-clears", ctrlRegs[5], 0);

    // R11: aborts inside a write byte, inside an instruction, inside a read
    wbuf[0] = 8'hE7;
    xfer(1'b0, 2'b01, 13'd2, 1, 21);
    readAll("R11 partial byte dropped");
    xfer(1'b0, 2'b01, 13'd3, 1, 9);
    wbuf[0] = 8'h66;
    xfer(1'b0, 2'b01, 13'd3, 1, -1);
    readAll("R11 fresh instruction after abort");
    xfer(1'b1, 2'b00, 13'd1, 3, 27);
    chk("R11 sdioOe released", sdioOe, 0);
    chk("R11 sdoOe released", sdoOe, 0);

    finish();
  end

endmodule